// File: doc/BRIEF.md
# Opcode-Fetch DRAM Refresh Sequencer

This block produces the bus activity of an instruction-fetch machine cycle, including the DRAM refresh that is folded into it. A one-clock start pulse begins a four-clock cycle. The first half of the cycle reads the opcode. The block drives the captured program address and asserts the memory request and read strobes. The second half refreshes memory. The block drives an internal row counter on the low byte of the address bus, forces the upper byte to zero, and asserts the memory request together with a refresh strobe.

The row counter advances by one when each fetch cycle ends. Consecutive fetches therefore sweep every DRAM row, and the counter wraps after the last row. The block has no separate refresh timer. Refresh happens only inside fetch cycles, so a stretch with no fetches leaves the counter where it is. A start pulse that arrives while a cycle is running is dropped. A one-clock done flag marks the final clock of every cycle.

Top module: `fetch_refresh_seq`

## Requirements
- R1: While reset is held, and in the first idle clock after reset, addr_bus is 0, the strobes mem_req, rd_strobe and rfsh_strobe are low, and cycle_done is low. The row counter starts at 0.
- R2: A fetch_start that is high at a rising edge while the block is idle begins a cycle. In the first and second clocks after that edge, addr_bus equals the pc_addr value sampled at that edge, mem_req and rd_strobe are high, and rfsh_strobe is low.
- R3: In the third and fourth clocks of a cycle, addr_bus[7:0] carries the current refresh row, addr_bus[15:8] is 0, mem_req and rfsh_strobe are high, and rd_strobe is low.
- R4: rd_strobe and rfsh_strobe are never high in the same clock.
- R5: cycle_done is high only in the fourth clock of a cycle, and for exactly one clock per cycle.
- R6: The refresh row increases by one at the end of every fetch cycle and wraps from 8'hFF to 8'h00.
- R7: Idle clocks without a fetch leave the refresh row unchanged. Outside a cycle, addr_bus is 0 and all strobes are low.
- R8: A fetch_start that is high at an edge while a cycle is in progress, including its last clock, is ignored. The cycle still lasts four clocks, the block returns to idle afterwards, and the row advances only once.
- R9: Changes on pc_addr after the start edge do not affect the address driven in the read half of the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_start | input | 1 | Start pulse for an opcode fetch cycle |
| pc_addr | input | 16 | Program address to fetch from |
| addr_bus | output | 16 | Address bus |
| mem_req | output | 1 | Memory request strobe |
| rd_strobe | output | 1 | Read strobe |
| rfsh_strobe | output | 1 | Refresh strobe |
| cycle_done | output | 1 | High in the last clock of each fetch cycle |

## Verification
The hardest condition to reach from the ports is the counter wrap. The row is visible only in the refresh half of a cycle, and 8'hFF becomes 8'h00 only after 256 complete fetches. The stimulus therefore runs a sweep of more than 256 back-to-back fetches and checks the row on the bus in every cycle. Some of those fetches are separated by idle gaps. Others keep fetch_start high throughout the cycle, so that ignored starts and idle stretches are both exercised across the wrap point.

// File: rtl/fr_pkg.sv
package fr_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_T4   = 3'd4
  } fr_phase_e;

  function automatic logic is_read_half(input fr_phase_e p);
    return (p == PH_T1) || (p == PH_T2);
  endfunction

  function automatic logic is_rfsh_half(input fr_phase_e p);
    return (p == PH_T3) || (p == PH_T4);
  endfunction
endpackage

// File: rtl/fr_phase_ctrl.sv
module fr_phase_ctrl
  import fr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fetch_start,
  output fr_phase_e phase,
  output logic      start_ok,
  output logic      end_cyc
);
  fr_phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (fetch_start) phase_d = PH_T1;
      PH_T1:   phase_d = PH_T2;
      PH_T2:   phase_d = PH_T3;
      PH_T3:   phase_d = PH_T4;
      PH_T4:   phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign phase    = phase_q;
  assign start_ok = fetch_start && (phase_q == PH_IDLE);
  assign end_cyc  = (phase_q == PH_T4);

  // R8
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |=> (phase_q != PH_T1));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_cyc |=> !end_cyc);

  // R2
  start_enters_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (phase_q == PH_T1));
endmodule

// File: rtl/fr_row_counter.sv
module fr_row_counter #(
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [ROW_W-1:0] row
);
  localparam logic [ROW_W-1:0] ROW_ONE = ROW_W'(1);

  function automatic logic [ROW_W-1:0] step_row(input logic [ROW_W-1:0] r);
    return r + ROW_ONE;
  endfunction

  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   row_q <= '0;
    else if (adv) row_q <= step_row(row_q);
  end

  assign row = row_q;

  // R6
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (row_q == $past(row_q) + ROW_ONE));

  // R7
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(row_q));
endmodule

// File: rtl/fr_bus_mux.sv
module fr_bus_mux
  import fr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ROW_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fr_phase_e         phase,
  input  logic              start_ok,
  input  logic [ADDR_W-1:0] pc_addr,
  input  logic [ROW_W-1:0]  row,
  output logic [ADDR_W-1:0] addr_bus,
  output logic              mem_req,
  output logic              rd_strobe,
  output logic              rfsh_strobe
);
  localparam int HI_W = ADDR_W - ROW_W;

  logic [ADDR_W-1:0] pc_q;
  logic              rd_half, rf_half;

  always_ff @(posedge clk) begin
    if (!rst_n)        pc_q <= '0;
    else if (start_ok) pc_q <= pc_addr;
  end

  assign rd_half = is_read_half(phase);
  assign rf_half = is_rfsh_half(phase);

  always_comb begin
    addr_bus = '0;
    if (rd_half)      addr_bus = pc_q;
    else if (rf_half) addr_bus = {{HI_W{1'b0}}, row};
  end

  assign mem_req     = rd_half || rf_half;
  assign rd_strobe   = rd_half;
  assign rfsh_strobe = rf_half;

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_strobe && rfsh_strobe));

  // R3
  rfsh_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_strobe |-> (addr_bus[ADDR_W-1:ROW_W] == '0) && (addr_bus[ROW_W-1:0] == row) && mem_req);

  // R9
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_T1) |=> $stable(addr_bus));
endmodule

// File: rtl/fetch_refresh_seq.sv
module fetch_refresh_seq
  import fr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ROW_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_start,
  input  logic [ADDR_W-1:0] pc_addr,
  output logic [ADDR_W-1:0] addr_bus,
  output logic              mem_req,
  output logic              rd_strobe,
  output logic              rfsh_strobe,
  output logic              cycle_done
);
  fr_phase_e        phase;
  logic             start_ok;
  logic             end_cyc;
  logic [ROW_W-1:0] row;

  fr_phase_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_start (fetch_start),
    .phase       (phase),
    .start_ok    (start_ok),
    .end_cyc     (end_cyc)
  );

  fr_row_counter #(.ROW_W(ROW_W)) u_row (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (end_cyc),
    .row   (row)
  );

  fr_bus_mux #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_mux (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase       (phase),
    .start_ok    (start_ok),
    .pc_addr     (pc_addr),
    .row         (row),
    .addr_bus    (addr_bus),
    .mem_req     (mem_req),
    .rd_strobe   (rd_strobe),
    .rfsh_strobe (rfsh_strobe)
  );

  assign cycle_done = end_cyc;

  // R5
  done_in_rfsh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |-> rfsh_strobe);
endmodule

// File: tb/fetch_refresh_seq_tb.sv
module fetch_refresh_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_start = 1'b0;
  logic [15:0] pc_addr = '0;
  logic [15:0] addr_bus;
  logic        mem_req, rd_strobe, rfsh_strobe, cycle_done;

  int errors = 0;
  int checks = 0;
  int exp_row = 0;
  bit done_flag = 0;

  fetch_refresh_seq u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_start(fetch_start), .pc_addr(pc_addr),
    .addr_bus(addr_bus), .mem_req(mem_req), .rd_strobe(rd_strobe),
    .rfsh_strobe(rfsh_strobe), .cycle_done(cycle_done)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pack_out();
    return {12'd0, cycle_done, rfsh_strobe, rd_strobe, mem_req, addr_bus};
  endfunction

  function automatic logic [31:0] idle_word();
    return 32'd0;
  endfunction

  function automatic logic [31:0] read_word(input logic [15:0] pc);
    return {12'd0, 1'b0, 1'b0, 1'b1, 1'b1, pc};
  endfunction

  function automatic logic [31:0] rfsh_word(input int row, input bit last);
    return {12'd0, last, 1'b1, 1'b0, 1'b1, 8'd0, 8'(row)};
  endfunction

  // Runs one fetch cycle starting from the current negedge.
  task automatic run_fetch(input logic [15:0] pc, input bit hold_start, input bit wiggle_pc);
    fetch_start = 1'b1;
    pc_addr = pc;
    @(negedge clk);
    fetch_start = hold_start;
    chk("R2 T1", pack_out(), read_word(pc));
    if (wiggle_pc) pc_addr = ~pc;
    @(negedge clk);
    chk(wiggle_pc ? "R9 T2" : "R2 T2", pack_out(), read_word(pc));
    @(negedge clk);
    chk("R3 T3", pack_out(), rfsh_word(exp_row, 1'b0));
    chk("R4 T3", 32'(rd_strobe & rfsh_strobe), 32'd0);
    @(negedge clk);
    chk("R3 R5 T4", pack_out(), rfsh_word(exp_row, 1'b1));
    exp_row = (exp_row + 1) % 256;
    @(negedge clk);
    fetch_start = 1'b0;
    chk(hold_start ? "R8 back to idle" : "R5 R7 idle after cycle", pack_out(), idle_word());
  endtask

  initial begin
    #200000;
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk("R1 in reset", pack_out(), idle_word());
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", pack_out(), idle_word());
    // first refresh row after reset must be 0
    run_fetch(16'h1234, 1'b0, 1'b0);
    // sweep past the wrap point with varied patterns
    for (int i = 0; i < 300; i++) begin
      logic [15:0] pc;
      pc = 16'((i * 16'h9e37) ^ 16'h5a5a);
      run_fetch(pc, (i % 5) == 2, (i % 7) == 3);
      if ((i % 11) == 4) begin
        for (int g = 0; g < 3; g++) begin
          @(negedge clk);
          chk("R7 idle gap", pack_out(), idle_word());
        end
      end
    end
    // check the wrap explicitly: drive up to row FF then one more fetch
    while (exp_row != 255) run_fetch(16'hffff, 1'b0, 1'b0);
    run_fetch(16'h8001, 1'b0, 1'b0);
    chk("R6 wrap to 00", 32'(exp_row), 32'd0);
    run_fetch(16'h4000, 1'b1, 1'b1);
    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule